// File: doc/BRIEF.md
# External Program Fetch Strobe Sequencer

This block drives the active-low read strobe toward external program memory in an 8051-class controller. It runs a twelve-phase machine cycle from the oscillator clock. At the edge that opens each cycle it samples the fetch address, the external-access select input, a flag that marks an external data cycle, and an idle request. From these it decides whether the fetch is served on chip or off chip, and it places the strobe and address-latch pulses at fixed phases inside the cycle.

Fetches go off chip when the select input is low, or when the select input is high and the fetch address lies above the on-chip range boundary. A build option makes every fetch external, for a variant that has no on-chip program store. A cycle spent on external data access gives up both strobe pulses and the second address-latch pulse. Idle keeps the bus quiet.

Top module: `prog_strobe_seq`

## Requirements
- R1: In an external fetch cycle, with phases numbered 0 to 11 from the cycle's first phase, `pstrb_n` is low in phases 2, 3, 4, 8, 9 and 10 and high in every other phase. Each pulse is therefore three oscillator periods wide, and the two pulses are six periods apart.
- R2: With `ext_sel` high and the sampled `pc` at or below 0x1FFF, the cycle is internal: `pstrb_n` stays high for all twelve phases and `fetch_ext` stays low.
- R3: With `ext_sel` high and the sampled `pc` at 0x2000 or above, the cycle is an external fetch.
- R4: With `ext_sel` low, the cycle is an external fetch for any `pc`, including 0x0000.
- R5: When `data_cyc` is sampled high, `pstrb_n` stays high for the whole cycle and `fetch_ext` is low.
- R6: `ale` is high in phases 0, 1, 6 and 7 of every non-idle cycle and low elsewhere. In a cycle with `data_cyc` sampled high, only the phase 0 and 1 pulse is produced.
- R7: When `idle` is sampled high, `pstrb_n` stays high and `ale` and `fetch_ext` stay low for the whole cycle.
- R8: While `rst_n` is low, `pstrb_n` is high and `ale` and `fetch_ext` are low, and asserting `rst_n` forces these values at once. After `rst_n` rises, phase 0 of the first cycle follows the third rising clock edge, and the inputs are sampled at that edge.
- R9: With the parameter ROMLESS set to 1, every non-idle, non-data cycle is an external fetch, whatever `ext_sel` and `pc` are.
- R10: The inputs are sampled only at the edge that starts phase 0. Changes during the cycle do not affect the outputs until the next cycle.
- R11: `fetch_ext` is high in all twelve phases of an external fetch cycle and changes only at the start of phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | External-access select; low forces all fetches off chip |
| pc | input | 16 | Address of the fetch in the coming cycle |
| data_cyc | input | 1 | Coming cycle performs an external data access |
| idle | input | 1 | Coming cycle is idle; bus stays quiet |
| pstrb_n | output | 1 | Active-low external program read strobe |
| ale | output | 1 | Address latch enable |
| fetch_ext | output | 1 | Current cycle fetches from external memory |

## Verification
The hardest case to reach from the ports is an input that changes partway through a cycle, because any such change must leave that cycle's outputs untouched. To create it, the driver flips `ext_sel` and inverts `pc` at the cycle's midpoint. In one case the flip would turn an internal fetch into an external one. In another it stays external, which shows that the strobe pattern keeps running without a break. The address boundary is covered on both sides: 0x1FFF is internal and 0x2000 is external. A second instance with the on-chip store removed runs on the same stimulus. A reset asserted in the middle of a strobe pulse checks that the outputs release asynchronously.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
  typedef struct packed {
    logic ext;
    logic data;
    logic idle;
  } cyc_attr_t;
endpackage

// File: rtl/pss_rst_sync.sv
`timescale 1ns/1ps
module pss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/pss_phase_ctr.sv
`timescale 1ns/1ps
module pss_phase_ctr #(
  parameter int PHASES = 12,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ph,
  output logic [PW-1:0] ph_nxt,
  output logic          last
);
  localparam logic [PW-1:0] PH_MAX = PW'(PHASES - 1);

  logic [PW-1:0] ph_q;

  always_comb begin
    last   = (ph_q == PH_MAX);
    ph_nxt = last ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_MAX;
    else        ph_q <= ph_nxt;
  end

  assign ph = ph_q;
endmodule

// File: rtl/pss_route.sv
`timescale 1ns/1ps
module pss_route #(
  parameter int              PC_W    = 16,
  parameter logic [PC_W-1:0] INT_TOP = 16'h1FFF,
  parameter bit              ROMLESS = 1'b0
) (
  input  logic            ext_sel,
  input  logic [PC_W-1:0] pc,
  output logic            ext
);
  generate
    if (ROMLESS) begin : g_romless
      assign ext = 1'b1;
    end else begin : g_rom
      assign ext = !ext_sel || (pc > INT_TOP);
    end
  endgenerate
endmodule

// File: rtl/pss_cycle_reg.sv
`timescale 1ns/1ps
module pss_cycle_reg
  import pss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  cyc_attr_t d,
  output cyc_attr_t q,
  output cyc_attr_t nxt
);
  cyc_attr_t attr_q;

  always_comb begin
    nxt = load ? d : attr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr_q <= '0;
    else        attr_q <= nxt;
  end

  assign q = attr_q;
endmodule

// File: rtl/pss_out_gen.sv
`timescale 1ns/1ps
module pss_out_gen
  import pss_pkg::*;
#(
  parameter int PHASES = 12,
  localparam int PW    = $clog2(PHASES),
  localparam int HALF  = PHASES / 2,
  localparam int ALE_L = HALF / 3,
  localparam int STB_S = ALE_L,
  localparam int STB_L = HALF / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ph,
  input  logic [PW-1:0] ph_nxt,
  input  cyc_attr_t     attr_q,
  input  cyc_attr_t     attr_nxt,
  output logic          pstrb_n,
  output logic          ale,
  output logic          fetch_ext
);
  logic          second;
  logic [PW-1:0] pos;
  logic          in_stb, in_ale;
  logic          stb_n_d, ale_d, fext_d;
  logic          stb_n_q, ale_q, fext_q;

  always_comb begin
    second  = (int'(ph_nxt) >= HALF);
    pos     = second ? ph_nxt - PW'(HALF) : ph_nxt;
    in_stb  = (int'(pos) >= STB_S) && (int'(pos) < STB_S + STB_L);
    in_ale  = (int'(pos) < ALE_L);
    fext_d  = attr_nxt.ext && !attr_nxt.data && !attr_nxt.idle;
    stb_n_d = !(fext_d && in_stb);
    ale_d   = !attr_nxt.idle && in_ale && !(attr_nxt.data && second);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_n_q <= 1'b1;
      ale_q   <= 1'b0;
      fext_q  <= 1'b0;
    end else begin
      stb_n_q <= stb_n_d;
      ale_q   <= ale_d;
      fext_q  <= fext_d;
    end
  end

  assign pstrb_n   = stb_n_q;
  assign ale       = ale_q;
  assign fetch_ext = fext_q;

  a_r6_ale_strobe_apart: assert property (@(posedge clk) disable iff (!rst_n)
    ale_q |-> stb_n_q);
  a_r11_fext_whole_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fext_q) |-> (ph == '0));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    attr_q.idle |-> (stb_n_q && !ale_q && !fext_q));
  a_r5_data_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    attr_q.data |-> (stb_n_q && !fext_q));
endmodule

// File: rtl/prog_strobe_seq.sv
`timescale 1ns/1ps
module prog_strobe_seq
  import pss_pkg::*;
#(
  parameter int              PC_W    = 16,
  parameter logic [PC_W-1:0] INT_TOP = 16'h1FFF,
  parameter bit              ROMLESS = 1'b0,
  parameter int              PHASES  = 12,
  localparam int             PW      = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_sel,
  input  logic [PC_W-1:0] pc,
  input  logic            data_cyc,
  input  logic            idle,
  output logic            pstrb_n,
  output logic            ale,
  output logic            fetch_ext
);
  logic          rst_s;
  logic [PW-1:0] ph, ph_nxt;
  logic          last;
  logic          route_ext;
  cyc_attr_t     attr_d, attr_q, attr_nxt;

  pss_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  pss_phase_ctr #(.PHASES(PHASES)) u_ph (
    .clk(clk), .rst_n(rst_s), .ph(ph), .ph_nxt(ph_nxt), .last(last)
  );

  pss_route #(.PC_W(PC_W), .INT_TOP(INT_TOP), .ROMLESS(ROMLESS)) u_route (
    .ext_sel(ext_sel), .pc(pc), .ext(route_ext)
  );

  always_comb begin
    attr_d.ext  = route_ext;
    attr_d.data = data_cyc;
    attr_d.idle = idle;
  end

  pss_cycle_reg u_cyc (
    .clk(clk), .rst_n(rst_s), .load(last), .d(attr_d), .q(attr_q), .nxt(attr_nxt)
  );

  pss_out_gen #(.PHASES(PHASES)) u_out (
    .clk(clk), .rst_n(rst_s), .ph(ph), .ph_nxt(ph_nxt),
    .attr_q(attr_q), .attr_nxt(attr_nxt),
    .pstrb_n(pstrb_n), .ale(ale), .fetch_ext(fetch_ext)
  );

  a_r2_no_strobe_internal: assert property (@(posedge clk) disable iff (!rst_s)
    !fetch_ext |-> pstrb_n);
  a_r1_pulse_min_width: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(pstrb_n) |=> !pstrb_n);
  a_r10_attr_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (ph != '0) |-> $stable(attr_q));
endmodule

// File: tb/sim_prog_strobe_seq.sv
`timescale 1ns/1ps
module sim_prog_strobe_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_sel;
  logic [15:0] pc;
  logic        data_cyc;
  logic        idle;
  logic        pstrb_n, ale, fetch_ext;
  logic        rl_pstrb_n, rl_ale, rl_fetch_ext;

  always #2.5 clk = ~clk;

  prog_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .pc(pc), .data_cyc(data_cyc),
    .idle(idle), .pstrb_n(pstrb_n), .ale(ale), .fetch_ext(fetch_ext)
  );

  prog_strobe_seq #(.ROMLESS(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .pc(pc), .data_cyc(data_cyc),
    .idle(idle), .pstrb_n(rl_pstrb_n), .ale(rl_ale), .fetch_ext(rl_fetch_ext)
  );

  typedef struct {
    logic  ext;
    logic  data;
    logic  idl;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_push = 0;
  int   n_pop  = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  task automatic chk(input string rq, input string tag, input int p,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) phase %0d: actual %b expected %b", rq, tag, p, act, exp);
    end
  endtask

  task automatic drive(input logic es, input logic [15:0] a, input logic d,
                       input logic i, input bit glitch, input string tag);
    exp_t e;
    ext_sel  = es;
    pc       = a;
    data_cyc = d;
    idle     = i;
    e.ext  = !es || (a > 16'h1FFF);
    e.data = d;
    e.idl  = i;
    e.tag  = tag;
    q.push_back(e);
    n_push++;
    repeat (6) @(negedge clk);
    if (glitch) begin
      ext_sel = ~ext_sel;
      pc      = ~pc;
    end
    repeat (6) @(negedge clk);
  endtask

  // Monitor: one popped item per machine cycle, twelve phase samples
  initial begin
    forever begin
      exp_t e;
      wait (n_push > n_pop);
      e = q.pop_front();
      for (int p = 0; p < 12; p++) begin
        logic pos_stb, pos_ale, fx, fx_rl;
        @(negedge clk);
        pos_stb = ((p % 6) >= 2) && ((p % 6) <= 4);
        pos_ale = (p % 6) < 2;
        fx      = e.ext && !e.data && !e.idl;
        fx_rl   = !e.data && !e.idl;
        // R1 strobe phases, R6 ALE phases, R11 whole-cycle fetch flag
        chk("R1", e.tag, p, pstrb_n, !(fx && pos_stb));
        chk("R6", e.tag, p, ale, !e.idl && pos_ale && !(e.data && p >= 6));
        chk("R11", e.tag, p, fetch_ext, fx);
        // R9 variant without on-chip store
        chk("R9", e.tag, p, rl_pstrb_n, !(fx_rl && pos_stb));
        chk("R9", e.tag, p, rl_fetch_ext, fx_rl);
      end
      n_pop++;
    end
  end

  initial begin
    rst_n    = 1'b0;
    ext_sel  = 1'b1;
    pc       = 16'h0000;
    data_cyc = 1'b0;
    idle     = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "in reset", 0, pstrb_n, 1'b1);
    chk("R8", "in reset", 0, ale, 1'b0);
    chk("R8", "in reset", 0, fetch_ext, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "sync stage", 0, pstrb_n, 1'b1);
    chk("R8", "sync stage", 0, ale, 1'b0);
    @(negedge clk);
    chk("R8", "sync stage", 0, ale, 1'b0);
    chk("R8", "sync stage", 0, fetch_ext, 1'b0);

    drive(1'b1, 16'h1FFF, 1'b0, 1'b0, 1'b0, "R2 at 1FFF");
    drive(1'b1, 16'h2000, 1'b0, 1'b0, 1'b0, "R3 at 2000");
    drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R4 pc 0");
    drive(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3 top");
    drive(1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, "R5 data ext");
    drive(1'b1, 16'h0040, 1'b0, 1'b0, 1'b0, "R2 low pc");
    drive(1'b0, 16'h0040, 1'b0, 1'b1, 1'b0, "R7 idle");
    drive(1'b1, 16'h0100, 1'b0, 1'b0, 1'b1, "R10 flip internal");
    drive(1'b0, 16'h3000, 1'b0, 1'b0, 1'b1, "R10 flip external");
    drive(1'b1, 16'h4000, 1'b1, 1'b0, 1'b0, "R5 data high pc");
    drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R4 final");

    wait (n_pop == n_push);
    // next cycle repeats the last inputs (external); reach phase 2
    repeat (3) @(negedge clk);
    chk("R1", "before async reset", 2, pstrb_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R8", "async reset", 2, pstrb_n, 1'b1);
    chk("R8", "async reset", 2, ale, 1'b0);
    chk("R8", "async reset", 2, fetch_ext, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule